// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences a processor core between three operating conditions. In run, everything is clocked. In idle, the CPU clock is gated while peripherals keep running. In power-down, the oscillator is stopped. Software asks for a reduced-power condition through two request inputs. The block then drives three enables (oscillator, CPU clock, peripheral clock), reports the current mode and emits a one-cycle wake pulse when the core resumes.

Wake handling differs by mode. Idle ends on any interrupt that is both pending and enabled. Power-down ends only on reset or on one of the low-numbered external interrupt lines, and only when that line is pending, enabled and configured as level-sensitive. Because the clock is stopped in power-down, a qualifying external line restarts the oscillator through an asynchronous clear, without waiting for any clock edge. A settle counter then keeps the CPU clock off while the oscillator stabilises. Register and memory contents are not touched by the block, so all state survives power-down.

Top module: `lpm_ctrl`

## Requirements
- R1: While reset is low, the outputs are mode=3 (settle), osc_en=1, cpu_clk_en=0, periph_clk_en=0 and wake=0. After reset is released, mode becomes 0 (run) on the RST_SETTLE_CYC-th rising edge, with both clock enables at 1 and no wake pulse.
- R2: In run, idle_req=1 at a rising edge moves the block to mode=1 (idle) at that edge. In idle, cpu_clk_en=0 while periph_clk_en=1 and osc_en=1.
- R3: In idle, any bit i with irq_pend[i]=1 and irq_en[i]=1 at a rising edge moves the block to run at that edge, and wake is 1 for exactly that one cycle. Pending but disabled bits leave the block in idle.
- R4: In run, pd_req=1 at a rising edge moves the block to mode=2 (power-down) at that edge, with osc_en, cpu_clk_en and periph_clk_en all 0. A power-down request wins over a simultaneous idle request.
- R5: In power-down, only bits i below N_EXT with irq_pend[i]=1, irq_en[i]=1 and ext_level[i]=1 (1 = level-sensitive, 0 = edge) count as wake sources. Disabled or edge-configured external lines and all bits at or above N_EXT leave osc_en at 0 and the mode at 2.
- R6: A qualifying power-down wake raises osc_en at once, without any clock edge. osc_en stays at 1 if the wake line is withdrawn before the next edge.
- R7: After a power-down wake, the block spends exactly SETTLE_CYC cycles in mode=3 with osc_en=1 and cpu_clk_en=0. It then enters run, and wake is 1 for that first run cycle only.
- R8: A request that arrives outside run is held and acted on at the next return to run, with power-down taking priority. Entering idle or power-down discards every held request, and so does reset.
- R9: Asserting reset during power-down raises osc_en immediately and restarts the reset settle sequence of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_req | input | 1 | Request to enter idle |
| pd_req | input | 1 | Request to enter power-down |
| irq_pend | input | N_IRQ | Interrupt pending flags; bits below N_EXT are external lines |
| irq_en | input | N_IRQ | Interrupt enable flags |
| ext_level | input | N_EXT | External line trigger mode, 1 = level, 0 = edge |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| wake | output | 1 | One-cycle pulse on resuming run after idle or power-down |
| mode | output | 2 | 0 run, 1 idle, 2 power-down, 3 settle |

## Verification
Some properties are checked by the assertions on every cycle. Each mode must show its own enable pattern. Requests taken in run must lead to the right mode. Idle must end exactly on an enabled pending interrupt. Power-down must not be left while the oscillator is off and no qualifying external line is active. The wake pulse must last one cycle and occur only in run. Other behaviour needs the bench's scenarios: the asynchronous oscillator restart between clock edges, the exact length of both settle windows, requests held across idle and discarded by reset, and the power-down filtering of randomly drawn pend, enable and trigger-mode patterns against a bench model.

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int N_IRQ          = 8,
  parameter int N_EXT          = 2,
  parameter int SETTLE_CYC     = 2048,
  parameter int RST_SETTLE_CYC = 1250000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_req,
  input  logic             pd_req,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic [N_EXT-1:0] ext_level,
  output logic             osc_en,
  output logic             cpu_clk_en,
  output logic             periph_clk_en,
  output logic             wake,
  output logic [1:0]       mode
);

  localparam int MAXC = (SETTLE_CYC > RST_SETTLE_CYC) ? SETTLE_CYC : RST_SETTLE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PD_LOAD  = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] RST_LOAD = CW'(RST_SETTLE_CYC - 1);

  typedef enum logic [1:0] {S_RUN = 2'd0, S_IDLE = 2'd1, S_PD = 2'd2, S_SET = 2'd3} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          from_pd, wake_q, pd_off, pend_pd, pend_idle;

  logic idle_ok, pd_ok, pd_clr_n, want_pd, want_idle, go_pd, go_idle;

  assign idle_ok   = |(irq_pend & irq_en);
  assign pd_ok     = |(irq_pend[N_EXT-1:0] & irq_en[N_EXT-1:0] & ext_level);
  assign pd_clr_n  = rst_n & ~pd_ok;
  assign want_pd   = pd_req | pend_pd;
  assign want_idle = idle_req | pend_idle;
  assign go_pd     = (state == S_RUN) && want_pd;
  assign go_idle   = (state == S_RUN) && !want_pd && want_idle;

  // Oscillator-off flag: released asynchronously by a qualifying wake line.
  always_ff @(posedge clk or negedge pd_clr_n) begin
    if (!pd_clr_n)  pd_off <= 1'b0;
    else if (go_pd) pd_off <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_pd   <= 1'b0;
      pend_idle <= 1'b0;
    end else if (go_pd || go_idle) begin
      pend_pd   <= 1'b0;
      pend_idle <= 1'b0;
    end else begin
      if (pd_req)   pend_pd   <= 1'b1;
      if (idle_req) pend_idle <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_SET;
      cnt     <= RST_LOAD;
      from_pd <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      wake_q <= 1'b0;
      unique case (state)
        S_RUN: begin
          if (go_pd)        state <= S_PD;
          else if (go_idle) state <= S_IDLE;
        end
        S_IDLE: begin
          if (idle_ok) begin
            state  <= S_RUN;
            wake_q <= 1'b1;
          end
        end
        S_PD: begin
          if (!pd_off) begin
            state   <= S_SET;
            cnt     <= PD_LOAD;
            from_pd <= 1'b1;
          end
        end
        S_SET: begin
          if (cnt == '0) begin
            state   <= S_RUN;
            wake_q  <= from_pd;
            from_pd <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_SET;
      endcase
    end
  end

  assign osc_en        = ~pd_off;
  assign cpu_clk_en    = (state == S_RUN);
  assign periph_clk_en = (state == S_RUN) || (state == S_IDLE);
  assign wake          = wake_q;
  assign mode          = state;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int N_IRQ = 8,
  parameter int N_EXT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idle_req,
  input logic             pd_req,
  input logic [N_IRQ-1:0] irq_pend,
  input logic [N_IRQ-1:0] irq_en,
  input logic [N_EXT-1:0] ext_level,
  input logic             osc_en,
  input logic             cpu_clk_en,
  input logic             periph_clk_en,
  input logic             wake,
  input logic [1:0]       mode
);

  logic any_en, ext_ok;
  assign any_en = |(irq_pend & irq_en);
  assign ext_ok = |(irq_pend[N_EXT-1:0] & irq_en[N_EXT-1:0] & ext_level);

  assert_idle_clocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd1 |-> (!cpu_clk_en && periph_clk_en && osc_en));

  assert_idle_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && idle_req) |=> (mode == 2'd1 || mode == 2'd2));

  assert_idle_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && any_en) |=> (mode == 2'd0 && wake));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !any_en) |=> mode == 2'd1);

  assert_pd_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && pd_req) |=> mode == 2'd2);

  assert_pd_clocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd2 |-> (!cpu_clk_en && !periph_clk_en));

  assert_pd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !osc_en && !ext_ok) |=> mode == 2'd2);

  assert_settle_clocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd3 |-> (osc_en && !cpu_clk_en && !periph_clk_en));

  assert_wake_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  assert_wake_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (mode == 2'd0 && cpu_clk_en && osc_en));

endmodule

bind lpm_ctrl lpm_ctrl_chk #(.N_IRQ(N_IRQ), .N_EXT(N_EXT)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .pd_req(pd_req),
  .irq_pend(irq_pend), .irq_en(irq_en), .ext_level(ext_level),
  .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
  .wake(wake), .mode(mode));

// File: tb/sim_lpm_ctrl.sv
module sim_lpm_ctrl;
  localparam int NI = 8, NE = 3, SC = 6, RC = 10;

  logic clk = 1'b0, rst_n = 1'b0, idle_req = 1'b0, pd_req = 1'b0;
  logic [NI-1:0] irq_pend = '0, irq_en = '0;
  logic [NE-1:0] ext_level = '0;
  logic osc_en, cpu_clk_en, periph_clk_en, wake;
  logic [1:0] mode;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  lpm_ctrl #(.N_IRQ(NI), .N_EXT(NE), .SETTLE_CYC(SC), .RST_SETTLE_CYC(RC)) u0 (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .pd_req(pd_req),
    .irq_pend(irq_pend), .irq_en(irq_en), .ext_level(ext_level),
    .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .wake(wake), .mode(mode));

  always #4 clk = ~clk;

  function automatic bit idle_wake_f(logic [NI-1:0] p, logic [NI-1:0] e);
    return |(p & e);
  endfunction

  function automatic bit pd_wake_f(logic [NI-1:0] p, logic [NI-1:0] e, logic [NE-1:0] l);
    return |(p[NE-1:0] & e[NE-1:0] & l);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_mode(input string req, input int exp);
    chk(mode == 2'(exp), req, mode, exp);
  endtask

  task automatic to_run();
    for (int i = 0; i < 30 && mode != 2'd0; i++) tick();
    chk_mode("R7 return to run", 0);
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed));
    #10;
    // R1: reset values
    chk_mode("R1 reset mode", 3);
    chk(osc_en && !cpu_clk_en && !periph_clk_en && !wake, "R1 reset outputs",
        {osc_en, cpu_clk_en, periph_clk_en, wake}, 4'b1000);
    tick();
    rst_n = 1'b1;
    for (int i = 0; i < RC - 1; i++) tick();
    chk_mode("R1 still settling", 3);
    tick();
    chk_mode("R1 run after reset settle", 0);
    chk(cpu_clk_en && periph_clk_en && !wake, "R1 run enables, no wake",
        {cpu_clk_en, periph_clk_en, wake}, 3'b110);

    // R2/R3: idle entry, disabled ignored, enabled wakes
    idle_req = 1'b1; tick(); idle_req = 1'b0;
    chk_mode("R2 idle entry", 1);
    chk(!cpu_clk_en && periph_clk_en && osc_en, "R2 idle enables",
        {cpu_clk_en, periph_clk_en, osc_en}, 3'b011);
    irq_pend = 8'h10; irq_en = 8'h0F; tick();
    chk_mode("R3 disabled pend stays idle", 1);
    irq_en = 8'h10; tick();
    chk_mode("R3 idle wake to run", 0);
    chk(wake == 1'b1, "R3 wake pulse", wake, 1);
    irq_pend = '0; irq_en = '0; tick();
    chk(wake == 1'b0, "R3 wake one cycle", wake, 0);

    // R4/R5/R6/R7: power-down priority, filtering, async restart, settle
    pd_req = 1'b1; idle_req = 1'b1; tick(); pd_req = 1'b0; idle_req = 1'b0;
    chk_mode("R4 pd wins over idle", 2);
    chk(!osc_en && !cpu_clk_en && !periph_clk_en, "R4 pd enables",
        {osc_en, cpu_clk_en, periph_clk_en}, 3'b000);
    irq_pend = 8'h20; irq_en = 8'h20; tick();
    chk(!osc_en && mode == 2'd2, "R5 non-external source ignored", osc_en, 0);
    irq_pend = 8'h02; irq_en = 8'h02; ext_level = 3'b000; #1;
    chk(!osc_en, "R5 edge-mode line ignored", osc_en, 0);
    tick(); chk_mode("R5 edge-mode stays pd", 2);
    irq_pend = 8'h01; irq_en = 8'h00; ext_level = 3'b001; tick();
    chk(!osc_en && mode == 2'd2, "R5 disabled level line ignored", osc_en, 0);
    irq_en = 8'h01; #1;
    chk(osc_en, "R6 async oscillator restart", osc_en, 1);
    irq_pend = '0; #1;
    chk(osc_en, "R6 restart held after withdraw", osc_en, 1);
    tick();
    chk_mode("R7 settle entry", 3);
    for (int i = 0; i < SC - 1; i++) tick();
    chk(mode == 2'd3 && !cpu_clk_en, "R7 settle length", mode, 3);
    tick();
    chk(mode == 2'd0 && wake, "R7 run with wake after settle", {mode, wake}, 1);
    tick();
    chk(!wake, "R7 wake one cycle", wake, 0);
    irq_en = '0; ext_level = '0;

    // R8: request held across idle
    idle_req = 1'b1; tick(); idle_req = 1'b0;
    pd_req = 1'b1; tick(); pd_req = 1'b0;
    chk_mode("R8 pd request while idle held", 1);
    irq_pend = 8'h80; irq_en = 8'h80; tick();
    irq_pend = '0; irq_en = '0;
    chk_mode("R8 idle woke", 0);
    tick();
    chk_mode("R8 held pd acted on", 2);
    // R9: reset during power-down
    rst_n = 1'b0; #1;
    chk(osc_en && mode == 2'd3, "R9 reset restarts oscillator", osc_en, 1);
    tick(); rst_n = 1'b1;
    for (int i = 0; i < RC; i++) tick();
    chk_mode("R9 run after reset settle", 0);

    // R8: reset discards held request
    idle_req = 1'b1; tick(); idle_req = 1'b0;
    pd_req = 1'b1; tick(); pd_req = 1'b0;
    rst_n = 1'b0; tick(); rst_n = 1'b1;
    for (int i = 0; i < RC; i++) tick();
    tick(); tick();
    chk_mode("R8 reset discarded held request", 0);

    // Random trials (R3, R5)
    for (int t = 0; t < 60; t++) begin
      bit use_pd, ex;
      logic [NI-1:0] p, e;
      logic [NE-1:0] l;
      use_pd = 1'($urandom % 2);
      if (use_pd) pd_req = 1'b1; else idle_req = 1'b1;
      tick(); pd_req = 1'b0; idle_req = 1'b0;
      chk_mode(use_pd ? "R4 random pd entry" : "R2 random idle entry", use_pd ? 2 : 1);
      p = NI'($urandom); e = NI'($urandom); l = NE'($urandom);
      ex = use_pd ? pd_wake_f(p, e, l) : idle_wake_f(p, e);
      irq_pend = p; irq_en = e; ext_level = l; #1;
      if (use_pd) chk(osc_en == ex, "R5 random pd osc", osc_en, ex);
      tick();
      if (use_pd) chk_mode("R5 random pd decision", ex ? 3 : 2);
      else        chk_mode("R3 random idle decision", ex ? 0 : 1);
      irq_pend = '0; irq_en = '0; ext_level = '0;
      if (!ex) begin
        irq_pend = 8'h01; irq_en = 8'h01; ext_level = 3'b001;
        tick();
        irq_pend = '0; irq_en = '0; ext_level = '0;
      end
      to_run();
    end

    finish_run();
  end
endmodule